// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core: two external request pins, two timer overflow events and one serial source formed from a receive flag and a transmit flag. Software sets an enable register and a priority register through a small write port. The controller keeps pending requests and picks at most one winner each time the core signals an instruction boundary. It then issues a one-cycle vector request with a 16-bit handler address and a one-hot acknowledge of the winning source.

Each source sits at one of two levels. The controller tracks a low-level and a high-level in-service state. A high-level request can interrupt a running low-level handler. A low-level request can never interrupt a high-level handler. A request never interrupts a handler of its own level. When two requests of the same level are pending together, a fixed polling order decides. The core reports the end of a handler with a return strobe.

Top module: `irq2_ctrl`

## Requirements
- R1: After reset, both registers read 0, `vec_valid` is 0, `ack_src` is 0, `vec_addr` is 0 and no level is in service.
- R2: A write with `cfg_sel`=0 loads the enable register and a write with `cfg_sel`=1 loads the priority register. `cfg_rdata` returns the full last written value of the register chosen by `cfg_sel`.
- R3: Enable bit 7 is a global enable, and no source is accepted while it is 0. The per-source enable bits are: bit 0 for external 0, bit 1 for timer 0, bit 2 for timer 1, bit 3 for external 1 and bit 4 for serial.
- R4: Among eligible requests of the same level, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial (source indices 0 to 4). Its vector address is 0x0003 + 8 × index, so the addresses are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. `ack_src` bit index equals the source index.
- R5: Priority register bit k (k = source index) set to 1 puts source k at the high level. When both levels have eligible requests, the high-level one wins.
- R6: While a low-level handler is in service and no high-level handler is in service, an eligible high-level request is granted at the next boundary.
- R7: While a high-level handler is in service, nothing is granted. While a low-level handler is in service, no low-level request is granted.
- R8: Arbitration happens only in a cycle where `insn_bound` is 1. `vec_valid` and `ack_src` are asserted for exactly the one cycle after that boundary cycle.
- R9: A return strobe ends the high-level service if one is active, and otherwise ends the low-level service.
- R10: When `ext_edge_mode[k]`=1, a falling edge on `ext_req_n[k]` is latched until that source is granted, and the grant clears the latch. When `ext_edge_mode[k]`=0, the request is the pin held low, with no latching.
- R11: A one-cycle `tmr_ovf[k]` pulse is latched as a pending timer request, and the latch is cleared when that timer is granted.
- R12: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag`. It is not cleared by a grant, so it is granted again after the return if a flag is still set.
- R13: When a return strobe and a boundary fall in the same cycle, arbitration in that cycle uses the in-service state from before the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 enable, 1 priority |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| ext_req_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | Per pin: 1 falling-edge latched, 0 level |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| insn_bound | input | 1 | Instruction boundary strobe |
| ret_strobe | input | 1 | Return-from-handler strobe |
| vec_valid | output | 1 | One-cycle vector request |
| vec_addr | output | 16 | Handler address of the last grant |
| ack_src | output | 5 | One-hot acknowledge of the granted source |

## Verification
A return strobe and an instruction boundary can fall in the same cycle. Then the end of a handler and the choice of the next one compete for the in-service state. The bench raises both strobes together, first while a low-level handler runs and then while a high-level handler runs, each time with a request of the same level pending. The check requires no grant in that cycle and a grant at the very next boundary. A second overlap, a new latch event arriving as the grant clears a latch, is covered by the set-wins rule in the source latches.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
   localparam int unsigned NSRC     = 5;
   localparam int unsigned SRC_EXT0 = 0;
   localparam int unsigned SRC_TMR0 = 1;
   localparam int unsigned SRC_EXT1 = 2;
   localparam int unsigned SRC_TMR1 = 3;
   localparam int unsigned SRC_SER  = 4;

   typedef logic [NSRC-1:0] src_vec_t;

   // Enable register bit that gates a given source index.
   function automatic int unsigned en_bit(input int unsigned src);
      case (src)
         SRC_EXT0: return 0;
         SRC_TMR0: return 1;
         SRC_EXT1: return 3;
         SRC_TMR1: return 2;
         default:  return 4;
      endcase
   endfunction

   // Lowest index wins: that is the polling order.
   function automatic src_vec_t first_hot(input src_vec_t req);
      src_vec_t r;
      r = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req[i]) r = src_vec_t'(1) << i;
      end
      return r;
   endfunction
endpackage

// File: rtl/irq2_regs.sv
module irq2_regs
   import irq2_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             sel,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             glb_en,
   output src_vec_t         en_vec,
   output src_vec_t         prio_vec
);
   localparam int unsigned GLB_BIT = REG_W - 1;

   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] prio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         prio_q <= '0;
      end else if (we) begin
         if (sel) prio_q <= wdata;
         else     en_q   <= wdata;
      end
   end

   assign rdata    = sel ? prio_q : en_q;
   assign glb_en   = en_q[GLB_BIT];
   assign prio_vec = prio_q[NSRC-1:0];

   for (genvar s = 0; s < NSRC; s++) begin : g_en_map
      assign en_vec[s] = en_q[en_bit(s)];
   end
endmodule

// File: rtl/irq2_src.sv
module irq2_src
   import irq2_pkg::*;
#(
   parameter int unsigned NEXT = 2,
   parameter int unsigned NTMR = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEXT-1:0] pin_n,
   input  logic [NEXT-1:0] edge_mode,
   input  logic [NTMR-1:0] tmr_ovf,
   input  logic            ser_rx,
   input  logic            ser_tx,
   input  src_vec_t        clr,
   output src_vec_t        pend
);
   // External k is source 2k, timer k is source 2k+1.
   for (genvar k = 0; k < NEXT; k++) begin : g_ext
      localparam int unsigned IDX = 2 * k;
      logic pin_q;
      logic flag_q;
      logic fall;

      assign fall = pin_q & ~pin_n[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_q  <= 1'b1;
            flag_q <= 1'b0;
         end else begin
            pin_q <= pin_n[k];
            if (!edge_mode[k])  flag_q <= 1'b0;
            else if (fall)      flag_q <= 1'b1;
            else if (clr[IDX])  flag_q <= 1'b0;
         end
      end

      assign pend[IDX] = edge_mode[k] ? flag_q : ~pin_n[k];
   end

   for (genvar k = 0; k < NTMR; k++) begin : g_tmr
      localparam int unsigned IDX = 2 * k + 1;
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           flag_q <= 1'b0;
         else if (tmr_ovf[k])  flag_q <= 1'b1;
         else if (clr[IDX])    flag_q <= 1'b0;
      end

      assign pend[IDX] = flag_q;
   end

   assign pend[SRC_SER] = ser_rx | ser_tx;
endmodule

// File: rtl/irq2_arb.sv
module irq2_arb
   import irq2_pkg::*;
#(
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_vec_t         pend,
   input  src_vec_t         en_vec,
   input  src_vec_t         prio_vec,
   input  logic             glb_en,
   input  logic             boundary,
   input  logic             reti,
   output src_vec_t         grant,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_addr,
   output src_vec_t         ack,
   output logic             svc_hi,
   output logic             svc_lo
);
   src_vec_t         elig;
   src_vec_t         hi_c;
   src_vec_t         lo_c;
   logic             take_hi;
   logic             take_lo;
   logic             drop_hi;
   logic             drop_lo;
   logic [VEC_W-1:0] addr_c;

   always_comb begin
      elig    = pend & en_vec & {NSRC{glb_en}};
      hi_c    = elig & prio_vec;
      lo_c    = elig & ~prio_vec;
      take_hi = boundary && !svc_hi && (hi_c != '0);
      take_lo = boundary && !svc_hi && !svc_lo && (hi_c == '0) && (lo_c != '0);
      if (take_hi)      grant = first_hot(hi_c);
      else if (take_lo) grant = first_hot(lo_c);
      else              grant = '0;
      drop_hi = reti && svc_hi;
      drop_lo = reti && !svc_hi && svc_lo;
      addr_c  = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) addr_c = VEC_W'(VEC_BASE + VEC_STRIDE * unsigned'(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_hi    <= 1'b0;
         svc_lo    <= 1'b0;
         vec_valid <= 1'b0;
         vec_addr  <= '0;
         ack       <= '0;
      end else begin
         svc_hi    <= (svc_hi && !drop_hi) || take_hi;
         svc_lo    <= (svc_lo && !drop_lo) || take_lo;
         vec_valid <= take_hi || take_lo;
         ack       <= grant;
         if (take_hi || take_lo) vec_addr <= addr_c;
      end
   end
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
   import irq2_pkg::*;
#(
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned PIN_SYNC   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic [1:0]       ext_req_n,
   input  logic [1:0]       ext_edge_mode,
   input  logic [1:0]       tmr_ovf,
   input  logic             ser_rx_flag,
   input  logic             ser_tx_flag,
   input  logic             insn_bound,
   input  logic             ret_strobe,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_addr,
   output logic [NSRC-1:0]  ack_src
);
   localparam int unsigned TOP_ADDR = VEC_BASE + VEC_STRIDE * (NSRC - 1);

   if (VEC_STRIDE == 0) begin : g_bad_stride
      $error("VEC_STRIDE must be nonzero");
   end
   if (TOP_ADDR >= (64'd1 << VEC_W)) begin : g_bad_vec
      $error("vector table does not fit in VEC_W bits");
   end
   if (REG_W < NSRC + 1) begin : g_bad_reg
      $error("REG_W too small for enables and global bit");
   end

   logic     [1:0] pins_n;
   logic           glb_en;
   src_vec_t       en_vec;
   src_vec_t       prio_vec;
   src_vec_t       pend;
   src_vec_t       grant;
   src_vec_t       ack_v;
   logic           svc_hi;
   logic           svc_lo;

   if (PIN_SYNC == 0) begin : g_pin_direct
      assign pins_n = ext_req_n;
   end else begin : g_pin_sync
      logic [1:0] st_q [PIN_SYNC];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < PIN_SYNC; i++) st_q[i] <= 2'b11;
         end else begin
            st_q[0] <= ext_req_n;
            for (int i = 1; i < PIN_SYNC; i++) st_q[i] <= st_q[i-1];
         end
      end
      assign pins_n = st_q[PIN_SYNC-1];
   end

   irq2_regs #(.REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .glb_en   (glb_en),
      .en_vec   (en_vec),
      .prio_vec (prio_vec)
   );

   irq2_src #(.NEXT(2), .NTMR(2)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (pins_n),
      .edge_mode (ext_edge_mode),
      .tmr_ovf   (tmr_ovf),
      .ser_rx    (ser_rx_flag),
      .ser_tx    (ser_tx_flag),
      .clr       (grant),
      .pend      (pend)
   );

   irq2_arb #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend),
      .en_vec    (en_vec),
      .prio_vec  (prio_vec),
      .glb_en    (glb_en),
      .boundary  (insn_bound),
      .reti      (ret_strobe),
      .grant     (grant),
      .vec_valid (vec_valid),
      .vec_addr  (vec_addr),
      .ack       (ack_v),
      .svc_hi    (svc_hi),
      .svc_lo    (svc_lo)
   );

   assign ack_src = ack_v;
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       insn_bound,
   input logic       ret_strobe,
   input logic       vec_valid,
   input logic [4:0] ack_src,
   input logic [4:0] prio_vec,
   input logic       glb_en,
   input logic       svc_hi,
   input logic       svc_lo
);
   // R8: the acknowledge is one-hot and present exactly with the request
   p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_src) && (vec_valid == (ack_src != 5'd0)));

   // R8: no vector without a boundary in the previous cycle
   p_needs_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(insn_bound));

   // R3: no vector while the global enable was clear
   p_needs_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(glb_en));

   // R7: a high-level handler is never interrupted
   p_hi_not_preempted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> !$past(svc_hi));

   // R7: a low-level grant never nests inside a low-level handler
   p_lo_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && ((ack_src & $past(prio_vec)) == 5'd0)) |-> !$past(svc_lo));

   // R6: every grant leaves some level in service
   p_grant_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (svc_hi || svc_lo));

   // R9: a return ends the high level first
   p_ret_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ret_strobe) && $past(svc_hi) && !vec_valid) |-> !svc_hi);

   // R9: with no high handler, a return ends the low level
   p_ret_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ret_strobe) && !$past(svc_hi) && $past(svc_lo) && !vec_valid) |-> !svc_lo);
endmodule

bind irq2_ctrl irq2_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_bound (insn_bound),
   .ret_strobe (ret_strobe),
   .vec_valid  (vec_valid),
   .ack_src    (ack_src),
   .prio_vec   (prio_vec),
   .glb_en     (glb_en),
   .svc_hi     (svc_hi),
   .svc_lo     (svc_lo)
);

// File: tb/irq2_ctrl_tb_top.sv
module irq2_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [1:0]  ext_req_n = 2'b11;
   logic [1:0]  ext_edge_mode = 2'b00;
   logic [1:0]  tmr_ovf = 2'b00;
   logic        ser_rx_flag = 1'b0;
   logic        ser_tx_flag = 1'b0;
   logic        insn_bound = 1'b0;
   logic        ret_strobe = 1'b0;
   logic        vec_valid;
   logic [15:0] vec_addr;
   logic [4:0]  ack_src;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq2_ctrl dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_sel       (cfg_sel),
      .cfg_wdata     (cfg_wdata),
      .cfg_rdata     (cfg_rdata),
      .ext_req_n     (ext_req_n),
      .ext_edge_mode (ext_edge_mode),
      .tmr_ovf       (tmr_ovf),
      .ser_rx_flag   (ser_rx_flag),
      .ser_tx_flag   (ser_tx_flag),
      .insn_bound    (insn_bound),
      .ret_strobe    (ret_strobe),
      .vec_valid     (vec_valid),
      .vec_addr      (vec_addr),
      .ack_src       (ack_src)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cfg_we = 1'b0; ext_req_n = 2'b11; ext_edge_mode = 2'b00; tmr_ovf = 2'b00;
      ser_rx_flag = 1'b0; ser_tx_flag = 1'b0; insn_bound = 1'b0; ret_strobe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_expect(input logic sel, input logic [7:0] exp, input string req);
      cfg_sel = sel;
      #1;
      chk(cfg_rdata == exp, req, cfg_rdata, exp);
   endtask

   // Boundary in one cycle; the grant is visible the cycle after.
   task automatic bound_expect(input bit exp_v, input logic [15:0] exp_a, input string req);
      logic [4:0] exp_ack;
      exp_ack = exp_v ? (5'd1 << ((exp_a - 16'd3) / 16'd8)) : 5'd0;
      @(negedge clk);
      insn_bound = 1'b1;
      @(negedge clk);
      insn_bound = 1'b0;
      chk(vec_valid == exp_v, req, vec_valid, exp_v);
      chk(ack_src == exp_ack, req, ack_src, exp_ack);
      if (exp_v) chk(vec_addr == exp_a, req, vec_addr, exp_a);
      @(negedge clk);
      chk(vec_valid == 1'b0, {req, " one-cycle"}, vec_valid, 0);
   endtask

   task automatic ret();
      @(negedge clk);
      ret_strobe = 1'b1;
      @(negedge clk);
      ret_strobe = 1'b0;
   endtask

   task automatic pulse_tmr(input int k);
      @(negedge clk);
      tmr_ovf[k] = 1'b1;
      @(negedge clk);
      tmr_ovf[k] = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      rd_expect(1'b0, 8'h00, "R1 enable reset");
      rd_expect(1'b1, 8'h00, "R1 priority reset");
      chk(vec_valid == 1'b0, "R1 vec_valid", vec_valid, 0);
      chk(ack_src == 5'd0, "R1 ack", ack_src, 0);
      chk(vec_addr == 16'd0, "R1 vec_addr", vec_addr, 0);
   endtask

   task automatic t_regs();
      do_reset();
      wr(1'b0, 8'hA5);
      wr(1'b1, 8'h3C);
      rd_expect(1'b0, 8'hA5, "R2 enable readback");
      rd_expect(1'b1, 8'h3C, "R2 priority readback");
   endtask

   task automatic t_enables();
      do_reset();
      wr(1'b0, 8'h1F);                 // all sources, global off
      pulse_tmr(0);
      bound_expect(1'b0, 16'h0, "R3 global off");
      wr(1'b0, 8'h82);                 // global + timer 0
      bound_expect(1'b1, 16'h000B, "R3 global on timer0");
      ret();
      ext_req_n[1] = 1'b0;             // external 1 level request
      wr(1'b0, 8'h84);                 // bit2 only: timer 1, not external 1
      bound_expect(1'b0, 16'h0, "R3 bit2 ignores ext1");
      wr(1'b0, 8'h88);                 // bit3: external 1
      bound_expect(1'b1, 16'h0013, "R3 bit3 ext1");
      ret();
      ext_req_n[1] = 1'b1;
      wr(1'b0, 8'h84);
      pulse_tmr(1);
      bound_expect(1'b1, 16'h001B, "R3 bit2 timer1");
      ret();
   endtask

   task automatic t_order();
      do_reset();
      wr(1'b0, 8'h9F);
      ext_req_n = 2'b00;
      ser_rx_flag = 1'b1;
      pulse_tmr(0);
      pulse_tmr(1);
      bound_expect(1'b1, 16'h0003, "R4 ext0 first");
      ret();
      ext_req_n[0] = 1'b1;
      bound_expect(1'b1, 16'h000B, "R4 timer0 second");
      ret();
      bound_expect(1'b1, 16'h0013, "R4 ext1 third");
      ret();
      ext_req_n[1] = 1'b1;
      bound_expect(1'b1, 16'h001B, "R4 timer1 fourth");
      ret();
      bound_expect(1'b1, 16'h0023, "R4 serial last");
      ret();
      ser_rx_flag = 1'b0;
   endtask

   task automatic t_hi_first();
      do_reset();
      wr(1'b0, 8'h9F);
      wr(1'b1, 8'h10);                 // serial high
      ext_req_n[0] = 1'b0;
      ser_rx_flag = 1'b1;
      bound_expect(1'b1, 16'h0023, "R5 high level wins");
      ret();
      ser_rx_flag = 1'b0;
      ext_req_n[0] = 1'b1;
   endtask

   task automatic t_preempt();
      do_reset();
      wr(1'b0, 8'h8F);
      wr(1'b1, 8'h02);                 // timer 0 high
      ext_req_n[0] = 1'b0;
      bound_expect(1'b1, 16'h0003, "R6 low handler starts");
      pulse_tmr(0);
      bound_expect(1'b1, 16'h000B, "R6 high preempts low");
      ext_req_n[1] = 1'b0;
      bound_expect(1'b0, 16'h0, "R7 nothing inside high");
      ret();
      bound_expect(1'b0, 16'h0, "R9 first return ends high only");
      ret();
      bound_expect(1'b1, 16'h0003, "R9 second return ends low");
      ret();
      ext_req_n = 2'b11;
   endtask

   task automatic t_hi_no_preempt();
      do_reset();
      wr(1'b0, 8'h83);
      wr(1'b1, 8'h03);                 // ext0 and timer0 both high
      ext_req_n[0] = 1'b0;
      bound_expect(1'b1, 16'h0003, "R7 high handler starts");
      ext_req_n[0] = 1'b1;
      pulse_tmr(0);
      bound_expect(1'b0, 16'h0, "R7 high not preempted by high");
      ret();
      bound_expect(1'b1, 16'h000B, "R7 waiting high served after return");
      ret();
   endtask

   task automatic t_edge();
      do_reset();
      wr(1'b0, 8'h81);
      ext_edge_mode[0] = 1'b1;
      @(negedge clk); ext_req_n[0] = 1'b0;
      @(negedge clk); ext_req_n[0] = 1'b1;
      repeat (2) @(negedge clk);
      bound_expect(1'b1, 16'h0003, "R10 edge latched");
      ret();
      bound_expect(1'b0, 16'h0, "R10 latch cleared by grant");
      ext_req_n[0] = 1'b0;              // new falling edge, held low
      bound_expect(1'b1, 16'h0003, "R10 second edge");
      ret();
      bound_expect(1'b0, 16'h0, "R10 held low is no new edge");
      ext_req_n[0] = 1'b1;
      ext_edge_mode[0] = 1'b0;
      bound_expect(1'b0, 16'h0, "R10 level mode pin high");
      ext_req_n[0] = 1'b0;
      bound_expect(1'b1, 16'h0003, "R10 level mode pin low");
      ret();
      ext_req_n[0] = 1'b1;
   endtask

   task automatic t_timer_clear();
      do_reset();
      wr(1'b0, 8'h82);
      pulse_tmr(0);
      repeat (3) @(negedge clk);
      bound_expect(1'b1, 16'h000B, "R11 pulse latched");
      ret();
      bound_expect(1'b0, 16'h0, "R11 cleared on entry");
   endtask

   task automatic t_serial();
      do_reset();
      wr(1'b0, 8'h90);
      ser_tx_flag = 1'b1;
      bound_expect(1'b1, 16'h0023, "R12 tx requests");
      ret();
      bound_expect(1'b1, 16'h0023, "R12 not cleared by grant");
      ser_tx_flag = 1'b0;
      ret();
      bound_expect(1'b0, 16'h0, "R12 idle when flags clear");
   endtask

   task automatic t_no_boundary();
      do_reset();
      wr(1'b0, 8'h81);
      ext_req_n[0] = 1'b0;
      repeat (4) begin
         @(negedge clk);
         chk(vec_valid == 1'b0, "R8 no grant without boundary", vec_valid, 0);
      end
      bound_expect(1'b1, 16'h0003, "R8 grant at boundary");
      ret();
      ext_req_n[0] = 1'b1;
   endtask

   task automatic collide(input string req);
      @(negedge clk);
      insn_bound = 1'b1; ret_strobe = 1'b1;
      @(negedge clk);
      insn_bound = 1'b0; ret_strobe = 1'b0;
      chk(vec_valid == 1'b0, req, vec_valid, 0);
   endtask

   task automatic t_collide();
      do_reset();
      wr(1'b0, 8'h81);
      ext_req_n[0] = 1'b0;
      bound_expect(1'b1, 16'h0003, "R13 low handler");
      collide("R13 low return with boundary");
      bound_expect(1'b1, 16'h0003, "R13 low granted next boundary");
      ret();
      wr(1'b1, 8'h01);
      bound_expect(1'b1, 16'h0003, "R13 high handler");
      collide("R13 high return with boundary");
      bound_expect(1'b1, 16'h0003, "R13 high granted next boundary");
      ret();
      ext_req_n[0] = 1'b1;
   endtask

   initial begin
      t_reset();
      t_regs();
      t_enables();
      t_order();
      t_hi_first();
      t_preempt();
      t_hi_no_preempt();
      t_edge();
      t_timer_clear();
      t_serial();
      t_no_boundary();
      t_collide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule